// File: doc/BRIEF.md
# Owner and Event Notification Unit

This unit tracks which host currently owns the device and tells that host when something happens. A 64-bit owner register holds the host's full address. The top 16 bits are the node number and the lower 48 bits are the offset inside that node. The owner register can change in only two ways: through an atomic compare-and-swap command, or through a bus reset. A bus reset always returns it to the "nobody owns this" value, `0xFFFF_0000_0000_0000`.

Event pulses arrive on a vector input. Any cycle that carries at least one set bit replaces the notification bitmask with that cycle's bits. If an owner is present at that moment, the unit then raises an outbound write request with a valid/acknowledge handshake. The request carries the owner address and the bitmask.

The unit also holds a stream-enable register. Software sets it with plain writes, and a bus reset clears it. Its nonzero state drives a run output that starts or stops every configured stream.

Top module: `evt_owner_unit`

## Requirements
- R1: After `rst`, and one cycle after any cycle with `bus_reset_i` high, the owner register reads `0xFFFF_0000_0000_0000` (bits 63:48 all ones, bits 47:0 zero).
- R2: A swap command (`cmd_op_i` = 2) on the owner register (`cmd_sel_i` = 0) returns the owner's prior value. It loads `cmd_wdata_i` only when that prior value equals `cmd_cmp_i`.
- R3: A write command (`cmd_op_i` = 1) to the owner register leaves it unchanged.
- R4: Every command cycle produces `rsp_valid_o` exactly one cycle later. `rsp_data_o` holds the selected register's value from before the command. The selector values are: 0 = owner, 1 = notification bitmask (zero-extended), 2 = stream enable (zero-extended), 3 = always 0. Op 0 is read, and op 3 acts as a read.
- R5: A cycle with nonzero `evt_i` replaces the notification bitmask with exactly those bits on the next cycle. Earlier bits are cleared, and all bits set in that cycle are kept together. Bit meanings: 0 = receive setup changed, 1 = transmit setup changed, 4 = lock changed, 5 = clock selection accepted, 6 = external status changed.
- R6: If the owner is not the no-owner value in the event cycle, and no request is outstanding, `ntf_req_o` rises two cycles after the event cycle. It carries `ntf_addr_o` = owner and `ntf_data_o` = the new bitmask.
- R7: Events that arrive while there is no owner are still latched in the bitmask. They raise no request, either at that time or after an owner is later installed.
- R8: While `ntf_req_o` is high and `ntf_ack_i` is low, the request, address and data hold. `ntf_req_o` is low in the cycle after an acknowledged cycle.
- R9: A write to selector 2 loads the low 32 bits of `cmd_wdata_i` into the stream-enable register. `stream_run_o` is high exactly when that register is nonzero. A bus reset clears it, and the reset wins over a write in the same cycle.
- R10: A bus reset wins over an owner swap issued in the same cycle. The response still returns the pre-command owner.
- R11: A group of events arriving while a request is outstanding yields one more request after the current one is acknowledged, carrying the newer bitmask.
- R12: The notification bitmask is read-only. Writes and swaps to selector 1 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset: clears the owner and the stream enable |
| cmd_valid_i | input | 1 | Register command valid |
| cmd_op_i | input | 2 | Operation: 0 read, 1 write, 2 swap, 3 read |
| cmd_sel_i | input | 2 | Register select: 0 owner, 1 bitmask, 2 stream enable, 3 none |
| cmd_wdata_i | input | 64 | Write data, or the new value for a swap |
| cmd_cmp_i | input | 64 | Compare operand for a swap |
| rsp_valid_o | output | 1 | Response valid, one cycle after a command |
| rsp_data_o | output | 64 | Register value from before the command |
| evt_i | input | NOTE_W | Event pulses, one bit per event kind |
| ntf_req_o | output | 1 | Outbound notification write request |
| ntf_ack_i | input | 1 | Acknowledge of the outbound request |
| ntf_addr_o | output | 64 | Destination address (the owner) |
| ntf_data_o | output | NOTE_W | Notification bitmask being sent |
| stream_run_o | output | 1 | High while the stream-enable register is nonzero |

## Verification
The bench attacks the owner guard from both sides. It sends a swap with a wrong compare operand, a plain write, and a swap in the same cycle as a bus reset. A design that skipped the compare or accepted plain writes would report a foreign owner on readback. It also latches events while no owner is present and then installs an owner. A design that queued those events would emit an unexpected write, and a design that lost them would read back a wrong bitmask. Finally, it raises a second event group while a request is held unacknowledged for several cycles. A design that let the outbound data follow the live bitmask, or that dropped the follow-up write, would show changing data or a missing second transfer.

// File: rtl/evt_owner_pkg.sv
package evt_owner_pkg;

    localparam int OWNER_W = 64;
    localparam int NODE_W  = 16;
    localparam int OFFS_W  = OWNER_W - NODE_W;

    localparam logic [OWNER_W-1:0] OWNER_NONE = {{NODE_W{1'b1}}, {OFFS_W{1'b0}}};

    // Bit positions of the named events in the bitmask
    localparam int EV_RX_SETUP  = 0;
    localparam int EV_TX_SETUP  = 1;
    localparam int EV_LOCK      = 4;
    localparam int EV_CLK_TAKEN = 5;
    localparam int EV_EXT_STAT  = 6;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_PEEK  = 2'd3
    } reg_op_e;

    typedef enum logic [1:0] {
        SEL_OWNER  = 2'd0,
        SEL_NOTICE = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_VOID   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               valid;
        reg_op_e            op;
        reg_sel_e           sel;
        logic [OWNER_W-1:0] wdata;
        logic [OWNER_W-1:0] cmp;
    } reg_cmd_t;

    function automatic logic cmd_is(reg_cmd_t c, reg_op_e op, reg_sel_e sel);
        return c.valid && (c.op == op) && (c.sel == sel);
    endfunction

    function automatic logic is_owned(logic [OWNER_W-1:0] owner);
        return owner != OWNER_NONE;
    endfunction

endpackage

// File: rtl/owner_cas_reg.sv
module owner_cas_reg
    import evt_owner_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset_i,
    input  logic               swap_i,
    input  logic [OWNER_W-1:0] cmp_i,
    input  logic [OWNER_W-1:0] new_i,
    output logic [OWNER_W-1:0] owner_o
);
    logic [OWNER_W-1:0] owner_q;

    always_ff @(posedge clk) begin
        if (rst || bus_reset_i) begin
            owner_q <= OWNER_NONE;
        end else if (swap_i && (cmp_i == owner_q)) begin
            owner_q <= new_i;
        end
    end

    assign owner_o = owner_q;
endmodule

// File: rtl/stream_enable_reg.sv
module stream_enable_reg #(
    parameter int EN_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_reset_i,
    input  logic            wr_i,
    input  logic [EN_W-1:0] wdata_i,
    output logic [EN_W-1:0] en_o,
    output logic            run_o
);
    logic [EN_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst || bus_reset_i) begin
            en_q <= '0;
        end else if (wr_i) begin
            en_q <= wdata_i;
        end
    end

    assign en_o  = en_q;
    assign run_o = |en_q;
endmodule

// File: rtl/notice_push_unit.sv
module notice_push_unit
    import evt_owner_pkg::*;
#(
    parameter int NOTE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset_i,
    input  logic [NOTE_W-1:0]  evt_i,
    input  logic [OWNER_W-1:0] owner_i,
    input  logic               ack_i,
    output logic [NOTE_W-1:0]  notice_o,
    output logic               req_o,
    output logic [OWNER_W-1:0] addr_o,
    output logic [NOTE_W-1:0]  data_o
);
    logic [NOTE_W-1:0]  notice_q;
    logic [NOTE_W-1:0]  data_q;
    logic [OWNER_W-1:0] addr_q;
    logic               pend_q;
    logic               req_q;
    logic               any_evt;
    logic               owned;
    logic               launch;

    always_comb begin
        any_evt = |evt_i;
        owned   = is_owned(owner_i);
        launch  = pend_q && !req_q && owned;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            notice_q <= '0;
            data_q   <= '0;
            addr_q   <= OWNER_NONE;
            pend_q   <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            if (any_evt) begin
                notice_q <= evt_i;
            end
            pend_q <= !bus_reset_i &&
                      ((any_evt && owned) || (pend_q && !launch && owned));
            if (launch) begin
                req_q  <= 1'b1;
                addr_q <= owner_i;
                data_q <= notice_q;
            end else if (req_q && ack_i) begin
                req_q <= 1'b0;
            end
        end
    end

    assign notice_o = notice_q;
    assign req_o    = req_q;
    assign addr_o   = addr_q;
    assign data_o   = data_q;
endmodule

// File: rtl/evt_owner_unit.sv
module evt_owner_unit
    import evt_owner_pkg::*;
#(
    parameter int NOTE_W = 32,
    parameter int EN_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_reset_i,
    input  logic               cmd_valid_i,
    input  logic [1:0]         cmd_op_i,
    input  logic [1:0]         cmd_sel_i,
    input  logic [OWNER_W-1:0] cmd_wdata_i,
    input  logic [OWNER_W-1:0] cmd_cmp_i,
    output logic               rsp_valid_o,
    output logic [OWNER_W-1:0] rsp_data_o,
    input  logic [NOTE_W-1:0]  evt_i,
    output logic               ntf_req_o,
    input  logic               ntf_ack_i,
    output logic [OWNER_W-1:0] ntf_addr_o,
    output logic [NOTE_W-1:0]  ntf_data_o,
    output logic               stream_run_o
);
    localparam int NOTE_PAD = OWNER_W - NOTE_W;
    localparam int EN_PAD   = OWNER_W - EN_W;

    reg_cmd_t           cmd;
    logic [OWNER_W-1:0] owner_q;
    logic [NOTE_W-1:0]  notice_q;
    logic [EN_W-1:0]    en_q;
    logic [OWNER_W-1:0] sel_val;

    always_comb begin
        cmd.valid = cmd_valid_i;
        cmd.op    = reg_op_e'(cmd_op_i);
        cmd.sel   = reg_sel_e'(cmd_sel_i);
        cmd.wdata = cmd_wdata_i;
        cmd.cmp   = cmd_cmp_i;
    end

    owner_cas_reg u_owner (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_i (bus_reset_i),
        .swap_i      (cmd_is(cmd, OP_SWAP, SEL_OWNER)),
        .cmp_i       (cmd.cmp),
        .new_i       (cmd.wdata),
        .owner_o     (owner_q)
    );

    stream_enable_reg #(.EN_W(EN_W)) u_enable (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_i (bus_reset_i),
        .wr_i        (cmd_is(cmd, OP_WRITE, SEL_ENABLE)),
        .wdata_i     (cmd.wdata[EN_W-1:0]),
        .en_o        (en_q),
        .run_o       (stream_run_o)
    );

    notice_push_unit #(.NOTE_W(NOTE_W)) u_notice (
        .clk         (clk),
        .rst         (rst),
        .bus_reset_i (bus_reset_i),
        .evt_i       (evt_i),
        .owner_i     (owner_q),
        .ack_i       (ntf_ack_i),
        .notice_o    (notice_q),
        .req_o       (ntf_req_o),
        .addr_o      (ntf_addr_o),
        .data_o      (ntf_data_o)
    );

    // Response carries the selected register's value before the command acts
    always_comb begin
        unique case (cmd.sel)
            SEL_OWNER:  sel_val = owner_q;
            SEL_NOTICE: sel_val = {{NOTE_PAD{1'b0}}, notice_q};
            SEL_ENABLE: sel_val = {{EN_PAD{1'b0}}, en_q};
            default:    sel_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            rsp_valid_o <= cmd.valid;
            if (cmd.valid) begin
                rsp_data_o <= sel_val;
            end
        end
    end
endmodule

// File: rtl/evt_owner_chk.sv
module evt_owner_chk
    import evt_owner_pkg::*;
#(
    parameter int NOTE_W = 32,
    parameter int EN_W   = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_reset,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic [1:0]         cmd_sel,
    input logic [OWNER_W-1:0] cmd_wdata,
    input logic [OWNER_W-1:0] cmd_cmp,
    input logic               rsp_valid,
    input logic [OWNER_W-1:0] owner,
    input logic [NOTE_W-1:0]  notice,
    input logic [EN_W-1:0]    en,
    input logic [NOTE_W-1:0]  evt,
    input logic               req,
    input logic               ack,
    input logic [OWNER_W-1:0] addr,
    input logic [NOTE_W-1:0]  data
);
    logic owner_swap;
    assign owner_swap = cmd_valid && (cmd_op == OP_SWAP) && (cmd_sel == SEL_OWNER);

    // R1
    owner_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> owner == OWNER_NONE);

    // R2
    owner_swap_take_chk: assert property (@(posedge clk) disable iff (rst)
        owner_swap && (cmd_cmp == owner) && !bus_reset |=> owner == $past(cmd_wdata));

    // R3
    owner_guard_chk: assert property (@(posedge clk) disable iff (rst)
        !owner_swap && !bus_reset |=> $stable(owner));

    // R4
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    // R4
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    // R5
    notice_replace_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> notice == $past(evt));

    // R7
    ntf_owned_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> addr != OWNER_NONE);

    // R8
    ntf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && $stable(addr) && $stable(data));

    // R8
    ntf_release_chk: assert property (@(posedge clk) disable iff (rst)
        req && ack |=> !req);

    // R9
    enable_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> en == '0);
endmodule

bind evt_owner_unit evt_owner_chk #(.NOTE_W(NOTE_W), .EN_W(EN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset_i),
    .cmd_valid (cmd_valid_i),
    .cmd_op    (cmd_op_i),
    .cmd_sel   (cmd_sel_i),
    .cmd_wdata (cmd_wdata_i),
    .cmd_cmp   (cmd_cmp_i),
    .rsp_valid (rsp_valid_o),
    .owner     (owner_q),
    .notice    (notice_q),
    .en        (en_q),
    .evt       (evt_i),
    .req       (ntf_req_o),
    .ack       (ntf_ack_i),
    .addr      (ntf_addr_o),
    .data      (ntf_data_o)
);

// File: tb/tb_evt_owner_unit.sv
module tb_evt_owner_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 32;
    localparam logic [63:0] NONE    = 64'hFFFF_0000_0000_0000;
    localparam logic [63:0] OWNER_A = 64'hFFC2_0000_0000_1000;
    localparam logic [63:0] OWNER_B = 64'hFFC5_0001_2000_0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_reset_i = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [1:0]  cmd_op_i = 2'd0;
    logic [1:0]  cmd_sel_i = 2'd0;
    logic [63:0] cmd_wdata_i = '0;
    logic [63:0] cmd_cmp_i = '0;
    logic        rsp_valid_o;
    logic [63:0] rsp_data_o;
    logic [NW-1:0] evt_i = '0;
    logic        ntf_req_o;
    logic        ntf_ack_i;
    logic [63:0] ntf_addr_o;
    logic [NW-1:0] ntf_data_o;
    logic        stream_run_o;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [63:0]   m_owner = NONE;
    logic [NW-1:0] m_notice = '0;
    logic [31:0]   m_en = '0;

    // Scoreboard queues
    logic [63:0]    rsp_q[$];
    string          rsp_tag_q[$];
    logic [95:0]    ntf_q[$];
    string          ntf_tag_q[$];

    evt_owner_unit dut (
        .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i),
        .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_sel_i(cmd_sel_i),
        .cmd_wdata_i(cmd_wdata_i), .cmd_cmp_i(cmd_cmp_i),
        .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
        .evt_i(evt_i), .ntf_req_o(ntf_req_o), .ntf_ack_i(ntf_ack_i),
        .ntf_addr_o(ntf_addr_o), .ntf_data_o(ntf_data_o),
        .stream_run_o(stream_run_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_val(input logic [1:0] sel);
        case (sel)
            2'd0:    return m_owner;
            2'd1:    return {32'h0, m_notice};
            2'd2:    return {32'h0, m_en};
            default: return 64'h0;
        endcase
    endfunction

    // Driver: issues one command, predicts its response and the new state
    task automatic issue(input logic [1:0] op, input logic [1:0] sel,
                         input logic [63:0] wd, input logic [63:0] cmp,
                         input string tag);
        cmd_valid_i = 1'b1;
        cmd_op_i    = op;
        cmd_sel_i   = sel;
        cmd_wdata_i = wd;
        cmd_cmp_i   = cmp;
        rsp_q.push_back(model_val(sel));
        rsp_tag_q.push_back(tag);
        if (op == 2'd2 && sel == 2'd0 && cmp == m_owner) m_owner = wd;
        if (op == 2'd1 && sel == 2'd2) m_en = wd[31:0];
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic fire(input logic [NW-1:0] e, input string tag);
        evt_i = e;
        m_notice = e;
        if (m_owner != NONE) begin
            ntf_q.push_back({m_owner, e});
            ntf_tag_q.push_back(tag);
        end
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Response monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid_o) begin
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected response", rsp_data_o, 64'h0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = rsp_q.pop_front();
                    t = rsp_tag_q.pop_front();
                    check(rsp_data_o == e, t, rsp_data_o, e);
                end
            end
        end
    end

    // Notification monitor: holds each request three cycles before acknowledging
    initial begin
        int hold;
        logic [63:0]   first_a;
        logic [NW-1:0] first_d;
        hold = 0;
        first_a = '0;
        first_d = '0;
        ntf_ack_i = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) continue;
            if (ntf_ack_i) begin
                ntf_ack_i = 1'b0;
                check(!ntf_req_o, "R8 request drops after acknowledge",
                      {63'h0, ntf_req_o}, 64'h0);
            end else if (ntf_req_o) begin
                if (hold == 0) begin
                    if (ntf_q.size() == 0) begin
                        check(1'b0, "R7 unexpected notification write",
                              ntf_addr_o, 64'h0);
                    end else begin
                        logic [95:0] e;
                        string t;
                        e = ntf_q.pop_front();
                        t = ntf_tag_q.pop_front();
                        check(ntf_addr_o == e[95:32], {t, " address"}, ntf_addr_o, e[95:32]);
                        check(ntf_data_o == e[31:0], {t, " data"},
                              {32'h0, ntf_data_o}, {32'h0, e[31:0]});
                    end
                    first_a = ntf_addr_o;
                    first_d = ntf_data_o;
                end else begin
                    check(ntf_addr_o == first_a && ntf_data_o == first_d,
                          "R8 request held stable", {32'h0, ntf_data_o}, {32'h0, first_d});
                end
                hold++;
                if (hold == 3) begin
                    ntf_ack_i = 1'b1;
                    hold = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check(!ntf_req_o && !rsp_valid_o && !stream_run_o, "R1 reset outputs idle",
              {61'h0, ntf_req_o, rsp_valid_o, stream_run_o}, 64'h0);
        issue(2'd0, 2'd0, '0, '0, "R1 owner after reset");
        issue(2'd0, 2'd2, '0, '0, "R9 enable after reset");

        // Selector 3 and op 3
        issue(2'd0, 2'd3, '0, '0, "R4 empty selector reads zero");
        issue(2'd3, 2'd0, '0, '0, "R4 op 3 reads like read");

        // Plain write to the owner is ignored
        issue(2'd1, 2'd0, OWNER_A, '0, "R3 write to owner returns old");
        issue(2'd0, 2'd0, '0, '0, "R3 owner unchanged by write");

        // Events with no owner: latched, never pushed
        fire(32'h0000_0011, "R7 no-owner events");
        for (int i = 0; i < 6; i++) begin
            check(!ntf_req_o, "R7 no request without owner", {63'h0, ntf_req_o}, 64'h0);
            @(negedge clk);
        end
        issue(2'd0, 2'd1, '0, '0, "R7 events latched without owner");

        // Compare-and-swap
        issue(2'd2, 2'd0, OWNER_B, 64'h0, "R2 swap miss returns old");
        issue(2'd0, 2'd0, '0, '0, "R2 owner unchanged after swap miss");
        issue(2'd2, 2'd0, OWNER_A, NONE, "R2 swap hit returns old");
        issue(2'd0, 2'd0, '0, '0, "R2 owner after swap hit");
        idle(6);

        // Events with an owner
        fire(32'h1 << 5, "R6 clock accepted notice");
        idle(8);
        issue(2'd0, 2'd1, '0, '0, "R5 older bits replaced");
        fire(32'h0000_0043, "R6 multi-bit notice");
        idle(8);
        issue(2'd0, 2'd1, '0, '0, "R5 same-cycle bits kept together");

        // Bitmask is read-only
        issue(2'd1, 2'd1, 64'h0, '0, "R12 write to bitmask returns old");
        issue(2'd2, 2'd1, 64'h5, 64'h43, "R12 swap to bitmask returns old");
        issue(2'd0, 2'd1, '0, '0, "R12 bitmask unchanged");

        // Events during an outstanding request
        fire(32'h1 << 4, "R11 first group");
        wait (ntf_req_o);
        @(negedge clk);
        fire(32'h1 << 1, "R11 second group");
        idle(14);
        check(ntf_q.size() == 0, "R11 both writes delivered", ntf_q.size(), 64'h0);

        // Stream enable
        issue(2'd1, 2'd2, 64'h5, '0, "R9 enable write returns old");
        check(stream_run_o, "R9 run after nonzero write", {63'h0, stream_run_o}, 64'h1);
        issue(2'd1, 2'd2, 64'h0, '0, "R9 enable second write returns old");
        check(!stream_run_o, "R9 stop after zero write", {63'h0, stream_run_o}, 64'h0);
        issue(2'd1, 2'd2, 64'h7, '0, "R9 enable third write");
        bus_reset_i = 1'b1;
        @(negedge clk);
        bus_reset_i = 1'b0;
        m_owner = NONE;
        m_en = '0;
        check(!stream_run_o, "R9 bus reset stops streams", {63'h0, stream_run_o}, 64'h0);
        issue(2'd0, 2'd2, '0, '0, "R9 enable cleared by bus reset");
        issue(2'd0, 2'd0, '0, '0, "R1 owner cleared by bus reset");

        // Bus reset beats same-cycle write and swap
        issue(2'd2, 2'd0, OWNER_B, NONE, "R2 second swap hit");
        bus_reset_i = 1'b1;
        cmd_valid_i = 1'b1;
        cmd_op_i    = 2'd2;
        cmd_sel_i   = 2'd0;
        cmd_wdata_i = OWNER_A;
        cmd_cmp_i   = OWNER_B;
        rsp_q.push_back(m_owner);
        rsp_tag_q.push_back("R10 swap with bus reset returns old");
        @(negedge clk);
        cmd_valid_i = 1'b0;
        bus_reset_i = 1'b0;
        m_owner = NONE;
        issue(2'd0, 2'd0, '0, '0, "R10 bus reset wins over swap");
        bus_reset_i = 1'b1;
        issue(2'd1, 2'd2, 64'h9, '0, "R9 write with bus reset returns old");
        bus_reset_i = 1'b0;
        m_en = '0;
        issue(2'd0, 2'd2, '0, '0, "R9 bus reset wins over write");

        idle(12);
        check(rsp_q.size() == 0, "R4 all responses seen", rsp_q.size(), 64'h0);
        check(ntf_q.size() == 0, "R6 all notifications seen", ntf_q.size(), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule